// File: doc/BRIEF.md
# Kernel Launch Control Register Slave

This block is the memory-mapped control slave that sits in front of a compute kernel. A host writes the launch setup into a bank of 64-bit registers: the dimension count, the work-group size, the per-dimension global sizes, group counts, local sizes and offsets, and three 64-bit pointer arguments. Each register is selected by a 4-bit word address. A host byte address maps to register index × 8, so byte 0x28 is register 5. Byte enables let the host fill each register as two 32-bit halves. The enable pattern 0x0F writes bits [31:0] and 0xF0 writes bits [63:32].

Register 0 is the control and status word. When the host writes 1 to its bit 0, the block emits a one-cycle launch pulse to the kernel. When the kernel reports completion, the block latches a done flag. Register 0 then reads as the value 2, and an interrupt line is raised until the next launch. The layout of the setup registers (indices 5 to 14) is fixed: register 5 holds the dimension count in its low half and the group size in its high half. Registers 6 to 11 hold the twelve geometry words, two per register with the low half first, in this order: global size ×3, group count ×3, local size ×3, global offset ×3. Registers 12 to 14 hold the pointers.

Top module: `kctl_regs`

## Requirements
- R1: After reset every register reads 0, and `start_o`, `irq_o` and `readdata_o` are 0.
- R2: A write changes only the bytes whose `byteenable_i` bit is set, with bit k selecting bits [8k+7:8k]. 0x0F writes the low half, 0xF0 writes the high half, and 0x00 changes nothing.
- R3: Registers 1 to 15 each keep all 64 written bits and return them unchanged on a read.
- R4: A read returns the selected register on `readdata_o` one cycle after `read_i`. `readdata_o` holds its value in cycles with no read.
- R5: Bit 0 of register 0 reads 1 only in the single cycle after a launch write, then clears by itself.
- R6: A write to register 0 with `byteenable_i[0]`=1 and `writedata_i[0]`=1 drives `start_o` high for exactly the next cycle. A write to register 0 with bit 0 of the data or of the byte enable at 0 gives no pulse.
- R7: A cycle with `done_i`=1 sets the done flag, which is bit 1 of register 0. With the flag set and no launch pending, register 0 reads 2.
- R8: The done flag stays set until the next launch, and `irq_o` equals the done flag.
- R9: A launch write clears the done flag. When `done_i` and a launch write fall in the same cycle, the launch wins and the flag ends up 0.
- R10: Bits [63:2] of register 0 ignore writes and always read 0.
- R11: A read and a write to the same register in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| address_i | input | 4 | Register word index |
| write_i | input | 1 | Write strobe |
| writedata_i | input | 64 | Write data |
| byteenable_i | input | 8 | Per-byte write enables |
| read_i | input | 1 | Read strobe |
| readdata_o | output | 64 | Registered read data |
| start_o | output | 1 | One-cycle kernel launch pulse |
| done_i | input | 1 | Kernel completion indication |
| irq_o | output | 1 | Completion interrupt, level |

## Verification
Two functions of the block can act in the same cycle.

The first pair is a completion report from the kernel and a new launch written by the host. The bench first raises `done_i` on its own, so that the flag and `irq_o` are already set. It then drives `done_i` high in the same cycle as a launch write. It judges the result by `start_o` pulsing, `irq_o` dropping to 0 and register 0 reading 0 afterwards.

The second pair is a read and a write to the same register in one cycle. The bench drives both strobes together and checks that the returned word is the old contents. It then reads again to confirm the new contents.

// File: rtl/kctl_pkg.sv
package kctl_pkg;
   localparam int unsigned CTL_IDX      = 0;
   localparam int unsigned CTL_GO_BIT   = 0;
   localparam int unsigned CTL_DONE_BIT = 1;
   localparam int unsigned GEOM_FIRST   = 5;
   localparam int unsigned GEOM_LAST    = 11;
   localparam int unsigned PTR_FIRST    = 12;
   localparam int unsigned PTR_LAST     = 14;
   localparam int unsigned MIN_REGS     = PTR_LAST + 1;

   typedef struct packed {
      logic done;
      logic go;
   } ctl_state_t;
endpackage

// File: rtl/kctl_lane_reg.sv
module kctl_lane_reg #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned NLANE = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NLANE-1:0]  lane_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (wr_en && lane_en[l]) begin
            lane_q <= wdata[l*LANE_W +: LANE_W];
         end
      end

      assign q[l*LANE_W +: LANE_W] = lane_q;

      a_r2_masked_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!(wr_en && lane_en[l])) |=> $stable(q[l*LANE_W +: LANE_W]));
   end
endmodule

// File: rtl/kctl_launch.sv
module kctl_launch
   import kctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch_i,
   input  logic       done_i,
   output ctl_state_t state_o
);
   ctl_state_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         st.go <= launch_i;
         if (launch_i) begin
            st.done <= 1'b0;
         end else if (done_i) begin
            st.done <= 1'b1;
         end
      end
   end

   assign state_o = st;

   a_r5_go_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (st.go && !launch_i) |=> !st.go);
   a_r7_done_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !launch_i) |=> st.done);
   a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st.done && !launch_i) |=> st.done);
   a_r9_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |=> !st.done);
endmodule

// File: rtl/kctl_rdport.sv
module kctl_rdport #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              read_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] regs_i [NUM_REGS],
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr_i == ADDR_W'(i)) sel = regs_i[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (read_i) begin
         rdata_o <= sel;
      end
   end

   a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !read_i |=> $stable(rdata_o));
endmodule

// File: rtl/kctl_regs.sv
module kctl_regs
   import kctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned NLANE   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] address_i,
   input  logic              write_i,
   input  logic [DATA_W-1:0] writedata_i,
   input  logic [NLANE-1:0]  byteenable_i,
   input  logic              read_i,
   output logic [DATA_W-1:0] readdata_o,
   output logic              start_o,
   input  logic              done_i,
   output logic              irq_o
);
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("NUM_REGS does not fit the address width");
   end
   if (NUM_REGS < MIN_REGS) begin : g_bad_map
      $error("NUM_REGS too small for the pointer registers");
   end

   logic [DATA_W-1:0] bank [NUM_REGS];
   logic              launch;
   ctl_state_t        ctl;

   assign launch = write_i && (address_i == ADDR_W'(CTL_IDX))
                 && byteenable_i[0] && writedata_i[CTL_GO_BIT];

   kctl_launch u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .done_i   (done_i),
      .state_o  (ctl)
   );

   always_comb begin
      bank[CTL_IDX] = '0;
      bank[CTL_IDX][CTL_GO_BIT]   = ctl.go;
      bank[CTL_IDX][CTL_DONE_BIT] = ctl.done;
   end

   for (genvar r = 1; r < NUM_REGS; r++) begin : g_reg
      logic sel_wr;
      assign sel_wr = write_i && (address_i == ADDR_W'(r));

      kctl_lane_reg #(
         .DATA_W (DATA_W),
         .LANE_W (LANE_W)
      ) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (sel_wr),
         .lane_en (byteenable_i),
         .wdata   (writedata_i),
         .q       (bank[r])
      );
   end

   kctl_rdport #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .read_i  (read_i),
      .addr_i  (address_i),
      .regs_i  (bank),
      .rdata_o (readdata_o)
   );

   assign start_o = ctl.go;
   assign irq_o   = ctl.done;

   a_r6_launch_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> start_o);
   a_r6_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> !start_o);
   a_r8_irq_tracks_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == bank[CTL_IDX][CTL_DONE_BIT]);
endmodule

// File: tb/kctl_regs_tb.sv
module kctl_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  address_i = '0;
   logic        write_i = 1'b0;
   logic [63:0] writedata_i = '0;
   logic [7:0]  byteenable_i = '0;
   logic        read_i = 1'b0;
   logic [63:0] readdata_o;
   logic        start_o;
   logic        done_i = 1'b0;
   logic        irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   logic [63:0] mdl [16];

   always #10 clk = ~clk;

   kctl_regs u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .address_i    (address_i),
      .write_i      (write_i),
      .writedata_i  (writedata_i),
      .byteenable_i (byteenable_i),
      .read_i       (read_i),
      .readdata_o   (readdata_o),
      .start_o      (start_o),
      .done_i       (done_i),
      .irq_o        (irq_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d, input logic [7:0] be);
      @(negedge clk);
      address_i = a; writedata_i = d; byteenable_i = be; write_i = 1'b1;
      @(negedge clk);
      write_i = 1'b0; byteenable_i = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [63:0] d);
      @(negedge clk);
      address_i = a; read_i = 1'b1;
      @(negedge clk);
      read_i = 1'b0;
      d = readdata_o;
   endtask

   function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                         input logic [7:0] be);
      logic [63:0] r = old;
      for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
      return r;
   endfunction

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] d;
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 start", {63'b0, start_o}, 64'd0);
      check("R1 irq", {63'b0, irq_o}, 64'd0);
      check("R1 readdata", readdata_o, 64'd0);
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         check("R1 reg", d, 64'd0);
      end

      // R2 R3 exhaustive byte-enable sweep over every storage register
      for (int a = 1; a < 16; a++) begin
         for (int be = 0; be < 256; be++) begin
            logic [63:0] pat;
            pat = 64'h9E3779B97F4A7C15 * 64'(a * 256 + be + 1);
            wr(4'(a), pat, 8'(be));
            mdl[a] = merge(mdl[a], pat, 8'(be));
            rd(4'(a), d);
            check("R2 R3 lane write", d, mdl[a]);
         end
      end

      // R2 halves: low then high, as a host fills the setup words
      wr(4'd12, 64'h0000_0000_2010_0000, 8'h0F);
      wr(4'd12, 64'hDEAD_BEEF_0000_0000, 8'hF0);
      mdl[12] = 64'hDEAD_BEEF_2010_0000;
      rd(4'd12, d);
      check("R2 halves", d, mdl[12]);

      // R4 readdata holds without a read
      rd(4'd12, d);
      repeat (3) @(negedge clk);
      check("R4 hold", readdata_o, mdl[12]);

      // R11 read and write together on one register
      @(negedge clk);
      address_i = 4'd7; writedata_i = 64'h1122_3344_5566_7788;
      byteenable_i = 8'hFF; write_i = 1'b1; read_i = 1'b1;
      @(negedge clk);
      write_i = 1'b0; read_i = 1'b0; byteenable_i = '0;
      check("R11 old value", readdata_o, mdl[7]);
      mdl[7] = 64'h1122_3344_5566_7788;
      rd(4'd7, d);
      check("R11 new value", d, mdl[7]);

      // R10 R6 writes to register 0 that must not launch
      wr(4'd0, 64'hFFFF_FFFF_FFFF_FFFE, 8'hFF);
      check("R6 no start data0", {63'b0, start_o}, 64'd0);
      rd(4'd0, d);
      check("R10 upper bits", d, 64'd0);
      wr(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFE);
      check("R6 no start be0", {63'b0, start_o}, 64'd0);
      rd(4'd0, d);
      check("R10 masked", d, 64'd0);

      // R6 R5 launch
      wr(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
      check("R6 start pulse", {63'b0, start_o}, 64'd1);
      address_i = 4'd0; read_i = 1'b1;
      @(negedge clk);
      read_i = 1'b0;
      check("R5 go reads 1", readdata_o, 64'd1);
      check("R6 pulse ends", {63'b0, start_o}, 64'd0);
      rd(4'd0, d);
      check("R5 go cleared", d, 64'd0);

      // R7 R8 completion
      @(negedge clk); done_i = 1'b1;
      @(negedge clk); done_i = 1'b0;
      check("R8 irq set", {63'b0, irq_o}, 64'd1);
      repeat (4) @(negedge clk);
      check("R8 irq held", {63'b0, irq_o}, 64'd1);
      rd(4'd0, d);
      check("R7 status 2", d, 64'd2);

      // R9 launch and done together: launch wins
      @(negedge clk);
      address_i = 4'd0; writedata_i = 64'd1; byteenable_i = 8'h0F;
      write_i = 1'b1; done_i = 1'b1;
      @(negedge clk);
      write_i = 1'b0; done_i = 1'b0; byteenable_i = '0;
      check("R9 start", {63'b0, start_o}, 64'd1);
      check("R9 irq cleared", {63'b0, irq_o}, 64'd0);
      @(negedge clk);
      rd(4'd0, d);
      check("R9 status", d, 64'd0);

      // R9 plain launch clears a set flag
      @(negedge clk); done_i = 1'b1;
      @(negedge clk); done_i = 1'b0;
      check("R7 set again", {63'b0, irq_o}, 64'd1);
      wr(4'd0, 64'd1, 8'h01);
      check("R9 clear by launch", {63'b0, irq_o}, 64'd0);

      // R3 storage untouched by control traffic
      for (int a = 1; a < 16; a++) begin
         rd(4'(a), d);
         check("R3 retained", d, mdl[a]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule